// File: doc/BRIEF.md
# Load/Store Address and Alignment Unit

This block is the memory-access stage of a small 32-bit processor. Each accepted operation carries an access size (byte, halfword or word), a direction (load or store), a signedness flag and an addressing form. The form is either a base register plus an offset register, or a base register plus a raw immediate field. The unit scales the immediate according to the access size and the base register kind, forms the effective address and checks that the address is aligned to the transfer size. For a legal access it issues one request on a 32-bit little-endian memory bus. A store request carries byte-lane strobes and store data replicated into the active lanes. A load takes the addressed byte or halfword from the returned word and widens it to 32 bits.

An access that is misaligned, or that is illegal in form, raises a one-cycle fault and issues no bus request. The request leaves a register one cycle after the operation is accepted. It then stays unchanged until the memory acknowledges it, and the unit refuses new operations while it waits. Register file, decode, condition flags and the bus protocol beyond the request/acknowledge pair belong to the surrounding pipeline.

Top module: `mem_access_unit`

## Requirements
- R1: With `op_reg_offs`=1 the effective address is `base_val + offs_val` modulo 2^32, and `imm_field` has no effect.
- R2: Word access (`op_size`=2) in immediate form with `op_sp_base`=1 uses an offset of `imm_field[7:0]`×4, which covers 0 to 1020.
- R3: Word access in immediate form with `op_sp_base`=0 uses an offset of `imm_field[4:0]`×4, which covers 0 to 124. Bits 7:5 of the field are ignored.
- R4: In immediate form a halfword access (`op_size`=1) uses an offset of `imm_field[4:0]`×2 and a byte access (`op_size`=0) uses `imm_field[4:0]`. `op_sp_base` and field bits 7:5 are ignored for both sizes.
- R5: A word access whose address has bits [1:0]≠0, or a halfword access whose address has bit 0 set, makes `fault` high for exactly the cycle after acceptance. No request is issued and `ld_valid` stays low.
- R6: An operation with `op_size`=3 faults in the same way. So does an operation with `op_signed`=1 in immediate form, since the signed forms exist only with an offset register.
- R7: On a request, `mem_strb` bit i marks byte lane i (lane i = `mem_wdata[8i+7:8i]`). A byte access sets only bit addr[1:0]. A halfword access sets 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1. A word access sets 4'b1111. A byte store replicates `store_val[7:0]` into all four lanes, a halfword store replicates `store_val[15:0]` into both halves, and a word store passes `store_val` unchanged.
- R8: For a load, the cycle after the acknowledge is sampled, `ld_valid` is high for one cycle. `ld_data` then holds byte `mem_rdata[8a+7:8a]` (a = addr[1:0]) or halfword `mem_rdata[16b+15:16b]` (b = addr[1]), zero-extended when `op_signed`=0 and sign-extended when it is 1, or else the whole word. A store never raises `ld_valid`.
- R9: `mem_req` rises the cycle after a legal operation is accepted. It stays high with address, strobes, direction and data unchanged until a rising clock edge samples `mem_ack` high, and it is low the cycle after that edge. `op_ready` is low exactly while `mem_req` is high.
- R10: An operation presented while `mem_req` is high is ignored. The pending request does not change and no further request or fault follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_ready | output | 1 | Unit can accept an operation |
| op_store | input | 1 | 1 = store, 0 = load |
| op_signed | input | 1 | Sign-extend loaded byte/halfword |
| op_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| op_reg_offs | input | 1 | 1 = offset register form, 0 = immediate form |
| op_sp_base | input | 1 | Base is the stack pointer (word immediate only) |
| base_val | input | 32 | Base register value |
| imm_field | input | 8 | Raw immediate field |
| offs_val | input | 32 | Offset register value |
| store_val | input | 32 | Store data register value |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_strb | output | 4 | Active byte lanes |
| mem_wdata | output | 32 | Lane-aligned store data |
| mem_ack | input | 1 | Memory accepts/completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| ld_valid | output | 1 | Load result valid (one cycle) |
| ld_data | output | 32 | Extended load result |
| fault | output | 1 | Misaligned or illegal access (one cycle) |

## Verification
The hardest case to reach is an operation arriving while a request is still waiting for its acknowledge. Its decoded address and lanes must not leak into the held request, and it must not start a second request after the acknowledge. The bench reaches it by holding `mem_ack` low for a varying number of cycles, and it presents a different, conflicting operation during that wait. It checks that the bus fields stay fixed and that the cycle after completion is quiet. Sign extension is reached by read patterns whose bytes alternate between set and clear top bits.

// File: rtl/mau_pkg.sv
`timescale 1ns/1ps
package mau_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;
endpackage

// File: rtl/mau_addr_gen.sv
`timescale 1ns/1ps
module mau_addr_gen
   import mau_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int IMM_W       = 8,
   parameter int SHORT_IMM_W = 5
) (
   input  acc_size_e         size,
   input  logic              reg_offs,
   input  logic              sp_base,
   input  logic              is_signed,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [IMM_W-1:0]  imm_field,
   input  logic [ADDR_W-1:0] offs_val,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              misalign,
   output logic              illegal
);
   localparam int PAD_L = ADDR_W - IMM_W;
   localparam int PAD_S = ADDR_W - SHORT_IMM_W;

   logic [ADDR_W-1:0] long_imm;
   logic [ADDR_W-1:0] short_imm;
   logic [ADDR_W-1:0] offset;

   assign long_imm  = {{PAD_L{1'b0}}, imm_field};
   assign short_imm = {{PAD_S{1'b0}}, imm_field[SHORT_IMM_W-1:0]};

   always_comb begin
      offset = '0;
      if (reg_offs) begin
         offset = offs_val;
      end else begin
         case (size)
            SZ_WORD: offset = sp_base ? (long_imm << 2) : (short_imm << 2);
            SZ_HALF: offset = short_imm << 1;
            SZ_BYTE: offset = short_imm;
            default: offset = '0;
         endcase
      end
   end

   assign eff_addr = base_val + offset;

   always_comb begin
      case (size)
         SZ_WORD: misalign = (eff_addr[1:0] != 2'b00);
         SZ_HALF: misalign = eff_addr[0];
         default: misalign = 1'b0;
      endcase
   end

   assign illegal = (size == SZ_BAD) || (is_signed && !reg_offs);
endmodule

// File: rtl/mau_store_lanes.sv
`timescale 1ns/1ps
module mau_store_lanes
   import mau_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  acc_size_e           size,
   input  logic [1:0]          lane,
   input  logic [DATA_W-1:0]   data,
   output logic [DATA_W/8-1:0] strb,
   output logic [DATA_W-1:0]   wdata
);
   localparam int LANES = DATA_W / 8;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [1:0] IDX = 2'(i);
      logic       en;
      logic [7:0] byte_v;
      always_comb begin
         case (size)
            SZ_BYTE: begin en = (lane == IDX);       byte_v = data[7:0];           end
            SZ_HALF: begin en = (lane[1] == IDX[1]); byte_v = data[8*(i%2) +: 8];  end
            SZ_WORD: begin en = 1'b1;                byte_v = data[8*i +: 8];      end
            default: begin en = 1'b0;                byte_v = data[8*i +: 8];      end
         endcase
      end
      assign strb[i]          = en;
      assign wdata[8*i +: 8]  = byte_v;
   end
endmodule

// File: rtl/mau_load_extract.sv
`timescale 1ns/1ps
module mau_load_extract
   import mau_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  acc_size_e         size,
   input  logic              is_signed,
   input  logic [1:0]        lane,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] result
);
   logic [7:0]  sel_b;
   logic [15:0] sel_h;

   assign sel_b = rdata[{lane, 3'b000} +: 8];
   assign sel_h = rdata[{lane[1], 4'b0000} +: 16];

   always_comb begin
      case (size)
         SZ_BYTE: result = {{(DATA_W-8){is_signed & sel_b[7]}}, sel_b};
         SZ_HALF: result = {{(DATA_W-16){is_signed & sel_h[15]}}, sel_h};
         default: result = rdata;
      endcase
   end
endmodule

// File: rtl/mem_access_unit.sv
`timescale 1ns/1ps
module mem_access_unit
   import mau_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int IMM_W       = 8,
   parameter int SHORT_IMM_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   output logic                op_ready,
   input  logic                op_store,
   input  logic                op_signed,
   input  logic [1:0]          op_size,
   input  logic                op_reg_offs,
   input  logic                op_sp_base,
   input  logic [ADDR_W-1:0]   base_val,
   input  logic [IMM_W-1:0]    imm_field,
   input  logic [ADDR_W-1:0]   offs_val,
   input  logic [DATA_W-1:0]   store_val,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_strb,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic                mem_ack,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                ld_valid,
   output logic [DATA_W-1:0]   ld_data,
   output logic                fault
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("mem_access_unit: DATA_W must be 32");
   end
   if (ADDR_W < IMM_W + 2) begin : g_bad_addr_w
      $error("mem_access_unit: ADDR_W too small for scaled immediate");
   end
   if (SHORT_IMM_W > IMM_W || SHORT_IMM_W < 1) begin : g_bad_short
      $error("mem_access_unit: SHORT_IMM_W out of range");
   end

   acc_size_e          cur_size;
   logic [ADDR_W-1:0]  ea;
   logic               misalign, illegal;
   logic [LANES-1:0]   strb_n;
   logic [DATA_W-1:0]  wdata_n;
   logic [DATA_W-1:0]  ld_next;
   acc_size_e          hold_size;
   logic               hold_signed;
   logic [1:0]         hold_lane;

   assign cur_size = acc_size_e'(op_size);

   mau_addr_gen #(
      .ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHORT_IMM_W(SHORT_IMM_W)
   ) u_agen (
      .size(cur_size), .reg_offs(op_reg_offs), .sp_base(op_sp_base),
      .is_signed(op_signed), .base_val(base_val), .imm_field(imm_field),
      .offs_val(offs_val), .eff_addr(ea), .misalign(misalign), .illegal(illegal)
   );

   mau_store_lanes #(.DATA_W(DATA_W)) u_st (
      .size(cur_size), .lane(ea[1:0]), .data(store_val),
      .strb(strb_n), .wdata(wdata_n)
   );

   mau_load_extract #(.DATA_W(DATA_W)) u_ld (
      .size(hold_size), .is_signed(hold_signed), .lane(hold_lane),
      .rdata(mem_rdata), .result(ld_next)
   );

   assign op_ready = !mem_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req     <= 1'b0;
         mem_we      <= 1'b0;
         mem_addr    <= '0;
         mem_strb    <= '0;
         mem_wdata   <= '0;
         ld_valid    <= 1'b0;
         ld_data     <= '0;
         fault       <= 1'b0;
         hold_size   <= SZ_WORD;
         hold_signed <= 1'b0;
         hold_lane   <= 2'b00;
      end else begin
         fault    <= 1'b0;
         ld_valid <= 1'b0;
         if (mem_req) begin
            if (mem_ack) begin
               mem_req <= 1'b0;
               if (!mem_we) begin
                  ld_valid <= 1'b1;
                  ld_data  <= ld_next;
               end
            end
         end else if (op_valid) begin
            if (misalign || illegal) begin
               fault <= 1'b1;
            end else begin
               mem_req     <= 1'b1;
               mem_we      <= op_store;
               mem_addr    <= ea;
               mem_strb    <= strb_n;
               mem_wdata   <= wdata_n;
               hold_size   <= cur_size;
               hold_signed <= op_signed;
               hold_lane   <= ea[1:0];
            end
         end
      end
   end
endmodule

// File: rtl/mau_checker.sv
`timescale 1ns/1ps
module mau_checker #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_ready,
   input logic                mem_req,
   input logic                mem_we,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W/8-1:0] mem_strb,
   input logic [DATA_W-1:0]   mem_wdata,
   input logic                mem_ack,
   input logic                ld_valid,
   input logic                fault
);
   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_strb)
                             && $stable(mem_we) && $stable(mem_wdata));
   // R9
   req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> !mem_req && op_ready);
   // R5
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !mem_req && !ld_valid);
   // R8
   ldv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(mem_req && mem_ack && !mem_we));
   // R7
   strb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_strb) == 1 || $countones(mem_strb) == 2
                   || $countones(mem_strb) == 4));
   // R5
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && (mem_strb == '1) |-> mem_addr[1:0] == 2'b00);
   // R5
   half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && ($countones(mem_strb) == 2) |-> !mem_addr[0]);
endmodule

bind mem_access_unit mau_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .mem_req(mem_req),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_strb(mem_strb),
   .mem_wdata(mem_wdata), .mem_ack(mem_ack), .ld_valid(ld_valid), .fault(fault)
);

// File: tb/sim_mem_access_unit.sv
`timescale 1ns/1ps
module sim_mem_access_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_store = 1'b0, op_signed = 1'b0;
   logic [1:0]  op_size = 2'd0;
   logic        op_reg_offs = 1'b0, op_sp_base = 1'b0;
   logic [31:0] base_val = '0, offs_val = '0, store_val = '0;
   logic [7:0]  imm_field = '0;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        op_ready, mem_req, mem_we, ld_valid, fault;
   logic [31:0] mem_addr, mem_wdata, ld_data;
   logic [3:0]  mem_strb;

   int tests = 0;
   int failed = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mem_access_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_store(op_store), .op_signed(op_signed), .op_size(op_size),
      .op_reg_offs(op_reg_offs), .op_sp_base(op_sp_base), .base_val(base_val),
      .imm_field(imm_field), .offs_val(offs_val), .store_val(store_val),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_strb(mem_strb), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data), .fault(fault)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_strb(input int sz, input logic [1:0] ln);
      if (sz == 0) return 4'b0001 << ln;
      if (sz == 1) return ln[1] ? 4'b1100 : 4'b0011;
      return 4'b1111;
   endfunction

   function automatic logic [31:0] exp_wdata(input int sz, input logic [31:0] d);
      if (sz == 0) return {4{d[7:0]}};
      if (sz == 1) return {2{d[15:0]}};
      return d;
   endfunction

   function automatic logic [31:0] exp_load(input int sz, input bit sg,
                                            input logic [1:0] ln, input logic [31:0] rd);
      logic [31:0] sh;
      if (sz == 0) begin
         sh = (rd >> (8 * ln)) & 32'hFF;
         if (sg && sh[7]) sh = sh - 32'h100;
         return sh;
      end
      if (sz == 1) begin
         sh = (rd >> (16 * ln[1])) & 32'hFFFF;
         if (sg && sh[15]) sh = sh - 32'h10000;
         return sh;
      end
      return rd;
   endfunction

   // One operation from presentation to completion; rq tags the address rule.
   task automatic do_op(input bit st, input bit sg, input int sz, input bit rg,
                        input bit sp, input logic [31:0] base, input logic [7:0] imm,
                        input logic [31:0] offs, input logic [31:0] sv,
                        input logic [31:0] rd, input int dly, input bit intrude,
                        input bit efault, input string frq,
                        input logic [31:0] eea, input string rq);
      @(negedge clk);
      op_valid = 1; op_store = st; op_signed = sg; op_size = 2'(sz);
      op_reg_offs = rg; op_sp_base = sp; base_val = base; imm_field = imm;
      offs_val = offs; store_val = sv;
      @(posedge clk);
      @(negedge clk);
      op_valid = 0;
      if (efault) begin
         chk(fault === 1'b1, frq, 32'(fault), 1);
         chk(mem_req === 1'b0, frq, 32'(mem_req), 0);
         @(posedge clk); @(negedge clk);
         chk(fault === 1'b0 && ld_valid === 1'b0 && mem_req === 1'b0, frq,
             {29'b0, fault, ld_valid, mem_req}, 0);
         return;
      end
      chk(fault === 1'b0, "R5", 32'(fault), 0);
      chk(mem_req === 1'b1 && op_ready === 1'b0, "R9", {30'b0, mem_req, op_ready}, 2);
      chk(mem_addr === eea, rq, mem_addr, eea);
      chk(mem_we === st, "R9", 32'(mem_we), 32'(st));
      chk(mem_strb === exp_strb(sz, eea[1:0]), "R7", 32'(mem_strb),
          32'(exp_strb(sz, eea[1:0])));
      if (st) chk(mem_wdata === exp_wdata(sz, sv), "R7", mem_wdata, exp_wdata(sz, sv));
      for (int w = 0; w < dly; w++) begin
         if (intrude && w == 0) begin
            op_valid = 1; op_store = ~st; op_size = 2'd0; op_reg_offs = 1;
            op_signed = 0; base_val = eea + 32'h55; offs_val = 32'h1; store_val = ~sv;
         end
         @(posedge clk); @(negedge clk);
         op_valid = 0;
         chk(mem_req === 1'b1 && mem_addr === eea, intrude ? "R10" : "R9",
             mem_addr, eea);
         chk(mem_strb === exp_strb(sz, eea[1:0]) && mem_we === st,
             intrude ? "R10" : "R9", 32'(mem_strb), 32'(exp_strb(sz, eea[1:0])));
      end
      mem_ack = 1; mem_rdata = rd;
      @(posedge clk); @(negedge clk);
      mem_ack = 0; mem_rdata = 32'hDEAD_BEEF;
      chk(mem_req === 1'b0 && op_ready === 1'b1, "R9", 32'(mem_req), 0);
      if (st) chk(ld_valid === 1'b0, "R8", 32'(ld_valid), 0);
      else begin
         chk(ld_valid === 1'b1, "R8", 32'(ld_valid), 1);
         chk(ld_data === exp_load(sz, sg, eea[1:0], rd), "R8", ld_data,
             exp_load(sz, sg, eea[1:0], rd));
      end
      @(posedge clk); @(negedge clk);
      chk(mem_req === 1'b0 && ld_valid === 1'b0 && fault === 1'b0,
          intrude ? "R10" : "R9", {29'b0, mem_req, ld_valid, fault}, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(mem_req === 0 && fault === 0 && ld_valid === 0 && op_ready === 1,
          "R9", {28'b0, mem_req, fault, ld_valid, op_ready}, 1);
      rst_n = 1;

      // R1, R5, R7, R8, R10: register-offset sweep over size, lane, direction, sign
      begin
         int k = 0;
         for (int sz = 0; sz < 3; sz++)
            for (int ln = 0; ln < 4; ln++)
               for (int st = 0; st < 2; st++)
                  for (int sg = 0; sg < 2; sg++) begin
                     logic [31:0] b, o, ea, rd;
                     bit mis;
                     b  = 32'h2000_0100 + 32'(k * 16);
                     o  = 32'h0000_0030 + 32'(ln);
                     ea = b + o;
                     rd = k[0] ? 32'h8A7B_C69D : 32'h7584_3962;
                     mis = (sz == 2 && ln != 0) || (sz == 1 && ln[0]);
                     do_op(st[0], sg[0], sz, 1, 0, b, 8'hFF, o, 32'hA1B2_C3D4 ^ 32'(k),
                           rd, k % 3, (k % 5 == 1) && (k % 3 != 0), mis, "R5", ea, "R1");
                     k++;
                  end
      end

      // R1: wrap-around of the sum
      do_op(0, 0, 2, 1, 0, 32'hFFFF_FFF8, 8'h00, 32'h0000_0010, 0, 32'h1234_5678,
            1, 0, 0, "R5", 32'h0000_0008, "R1");

      // R2, R3, R4, R5: immediate sweep over every field value
      for (int md = 0; md < 4; md++)
         for (int im = 0; im < 256; im++) begin
            int sz; bit sp; logic [31:0] off, b; bit mis; string rq;
            sz = (md < 2) ? 2 : (md == 2 ? 1 : 0);
            sp = (md == 0) || (md == 3 && im[0]);
            case (md)
               0: begin off = 32'(im) * 4;        rq = "R2"; end
               1: begin off = 32'(im % 32) * 4;   rq = "R3"; end
               2: begin off = 32'(im % 32) * 2;   rq = "R4"; end
               default: begin off = 32'(im % 32); rq = "R4"; end
            endcase
            b = 32'h3000_0400 + ((im % 7 == 3) ? 32'd1 : 32'd0);
            mis = (b[0] && sz != 0);
            do_op(im[1], 0, sz, 0, sp, b, 8'(im), 32'hFFFF_0000, 32'(im) * 32'h0101_0101,
                  32'hC3A5_5A3C, 0, 0, mis, "R5", b + off, rq);
         end

      // R6: illegal forms
      do_op(0, 1, 0, 0, 0, 32'h4000_0000, 8'h01, 0, 0, 0, 0, 0, 1, "R6", 0, "R6");
      do_op(0, 1, 1, 0, 0, 32'h4000_0000, 8'h02, 0, 0, 0, 0, 0, 1, "R6", 0, "R6");
      do_op(1, 1, 2, 0, 1, 32'h4000_0000, 8'h02, 0, 0, 0, 0, 0, 1, "R6", 0, "R6");
      do_op(0, 0, 3, 1, 0, 32'h4000_0000, 8'h00, 0, 0, 0, 0, 0, 1, "R6", 0, "R6");
      do_op(1, 0, 3, 0, 0, 32'h4000_0000, 8'h00, 0, 0, 0, 0, 0, 1, "R6", 0, "R6");

      // R10: long wait with a conflicting operation
      do_op(1, 0, 1, 1, 0, 32'h5000_0002, 8'h00, 32'h0, 32'hCAFE_F00D, 0,
            4, 1, 0, "R5", 32'h5000_0002, "R1");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         tests++;
         failed++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, failed);
         $finish;
      end
   end
endmodule